// File: doc/BRIEF.md
# Page Access Alarm Counters

This block keeps two down-counters for every shareable page that lives in another node's memory. One counter tracks loads and the other tracks stores. Each remote access seen on the host bus arrives as one transfer on a valid/ready access stream. The transfer carries the page number and whether it was a load or a store, and it decrements the matching counter. A counter that is already zero stays at zero. When a counter steps from one down to zero, the block latches an interrupt cause that holds the page number and the access kind. The cause stays until software clears it by writing a one.

Software loads a small value into a counter to be alarmed after that many accesses, which supports replication decisions. It loads a large value and samples the counter now and then to gather access statistics. It sets and reads counters through a plain command port while accesses keep flowing. The counters sit in a synchronous RAM, one bank per access kind. Each operation is a two-cycle read-modify-write, and results are forwarded between consecutive operations to the same entry so that no decrement is lost.

Access stream rules: a transfer is taken on a rising clock edge where `acc_valid` and `acc_ready` are both high. `acc_ready` is driven low in two cases. The first is any cycle in which software presents a read. The second is any cycle in which software presents a write to a different entry. If software writes the entry the access targets in the same cycle, `acc_ready` stays high and the access is taken and discarded. The source must hold its transfer stable while `acc_ready` is low.

Top module: `pac_alarm_top`

## Requirements
- R1: After reset, `irq` and `sw_rdata_valid` are low and `acc_ready` is high while no software command is presented.
- R2: An accepted access with `acc_write`=0 decrements the load counter of `acc_page`, and one with `acc_write`=1 decrements the store counter. The counter of the other kind is left unchanged.
- R3: An access to a counter that holds zero leaves it at zero and latches no new interrupt cause.
- R4: An access that takes a counter from one to zero sets `irq` two clock edges after it is accepted. `irq_page` then holds the page and `irq_kind` the kind (0 load, 1 store).
- R5: A software write (`sw_write`=1) stores `sw_wdata` into the counter selected by `sw_page` and `sw_kind` (0 load, 1 store). A software read (`sw_write`=0) is answered in the cycle after its accepting edge: `sw_rdata_valid` is high and `sw_rdata` holds the counter value.
- R6: Accesses to the same counter on consecutive cycles each take effect, so N accepted accesses lower the counter by N unless it reaches zero first.
- R7: `acc_ready` is low while a software read is presented, and while a software write to a different entry is presented. A stalled access is neither counted nor lost: it is taken once `acc_ready` returns high.
- R8: When a software write and an access target the same counter in the same cycle, the access is accepted and discarded, and the counter takes the written value.
- R9: While a cause is pending, later alarms are not recorded and `irq_page` and `irq_kind` stay stable until `irq_clr` is pulsed. If an alarm occurs in the same cycle as `irq_clr`, the new cause is latched.
- R10: A software read issued in the cycle right after an access to the same counter returns the decremented value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Remote access transfer present |
| acc_ready | output | 1 | Block can take the access this cycle |
| acc_page | input | PW (8) | Page number of the remote access |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| sw_valid | input | 1 | Software command present |
| sw_write | input | 1 | 1 to set a counter, 0 to read it |
| sw_page | input | PW (8) | Page selected by software |
| sw_kind | input | 1 | Counter kind: 0 load, 1 store |
| sw_wdata | input | CW (16) | Value to store |
| sw_rdata_valid | output | 1 | Read answer present |
| sw_rdata | output | CW (16) | Counter value answered |
| irq | output | 1 | Interrupt cause pending |
| irq_page | output | PW (8) | Page of the pending cause |
| irq_kind | output | 1 | Kind of the pending cause |
| irq_clr | input | 1 | Write-one-to-clear of the pending cause |

## Verification
The main function is driven through a table of preset, access, read-back and interrupt-probe steps. These steps separate the two kinds of counter on one page and tell a counter stepping down normally from one that has saturated at zero. Bursts of accesses on consecutive cycles, followed at once by a read, tell a forwarded result from a stale RAM word. Software commands that coincide with accesses, on the same entry and on different entries, separate the discard case from the stall case. Back-to-back alarms and an alarm that lands on the clear pulse show whether the first cause is held and whether a new cause survives the clear.

// File: rtl/pac_pkg.sv
package pac_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_DEC  = 2'd1,
    OP_SET  = 2'd2,
    OP_GET  = 2'd3
  } pac_op_e;

  localparam int unsigned NUM_KINDS = 2;
endpackage

// File: rtl/pac_ram.sv
module pac_ram #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata
);
  logic [DW-1:0] mem [DEPTH];

  // Read returns the word as it was before a same-edge write.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pac_rmw.sv
module pac_rmw
  import pac_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  pac_op_e       op,
  input  logic [DW-1:0] cur,
  input  logic [DW-1:0] set_val,
  output logic          we,
  output logic [DW-1:0] nxt,
  output logic          alarm
);
  logic is_zero;
  logic is_one;

  assign is_zero = (cur == '0);
  assign is_one  = (cur == DW'(1));

  always_comb begin
    we    = 1'b0;
    nxt   = cur;
    alarm = 1'b0;
    unique case (op)
      OP_DEC: begin
        if (!is_zero) begin
          we    = 1'b1;
          nxt   = cur - DW'(1);
          alarm = is_one;
        end
      end
      OP_SET: begin
        we  = 1'b1;
        nxt = set_val;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pac_pend.sv
module pac_pend #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev,
  input  logic [PW-1:0] ev_page,
  input  logic          ev_kind,
  input  logic          clr,
  output logic          pending,
  output logic [PW-1:0] page,
  output logic          kind
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      page    <= '0;
      kind    <= 1'b0;
    end else if (ev && (!pending || clr)) begin
      pending <= 1'b1;
      page    <= ev_page;
      kind    <= ev_kind;
    end else if (clr) begin
      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/pac_alarm_top.sv
module pac_alarm_top
  import pac_pkg::*;
#(
  parameter int unsigned NUM_PAGES = 256,
  parameter int unsigned CW        = 16,
  localparam int unsigned PW       = $clog2(NUM_PAGES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  output logic          acc_ready,
  input  logic [PW-1:0] acc_page,
  input  logic          acc_write,
  input  logic          sw_valid,
  input  logic          sw_write,
  input  logic [PW-1:0] sw_page,
  input  logic          sw_kind,
  input  logic [CW-1:0] sw_wdata,
  output logic          sw_rdata_valid,
  output logic [CW-1:0] sw_rdata,
  output logic          irq,
  output logic [PW-1:0] irq_page,
  output logic          irq_kind,
  input  logic          irq_clr
);
  // Issue stage: pick one operation per cycle.
  logic          hit_same;
  pac_op_e       s0_op;
  logic [PW-1:0] s0_page;
  logic          s0_kind;
  logic [CW-1:0] s0_data;

  assign hit_same  = sw_write && (sw_page == acc_page) && (sw_kind == acc_write);
  assign acc_ready = !sw_valid || hit_same;

  always_comb begin
    s0_op   = OP_NONE;
    s0_page = acc_page;
    s0_kind = acc_write;
    s0_data = sw_wdata;
    if (sw_valid) begin
      s0_op   = sw_write ? OP_SET : OP_GET;
      s0_page = sw_page;
      s0_kind = sw_kind;
    end else if (acc_valid) begin
      s0_op = OP_DEC;
    end
  end

  // Modify stage registers.
  pac_op_e       s1_op;
  logic [PW-1:0] s1_page;
  logic          s1_kind;
  logic [CW-1:0] s1_data;
  logic          s1_fwd;
  logic [CW-1:0] s1_fwd_val;
  logic [CW-1:0] s1_cur;
  logic          s1_we;
  logic [CW-1:0] s1_nxt;
  logic          s1_alarm;
  logic [CW-1:0] bank_q [NUM_KINDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_op      <= OP_NONE;
      s1_page    <= '0;
      s1_kind    <= 1'b0;
      s1_data    <= '0;
      s1_fwd     <= 1'b0;
      s1_fwd_val <= '0;
    end else begin
      s1_op      <= s0_op;
      s1_page    <= s0_page;
      s1_kind    <= s0_kind;
      s1_data    <= s0_data;
      s1_fwd     <= (s0_op != OP_NONE) && s1_we &&
                    (s0_page == s1_page) && (s0_kind == s1_kind);
      s1_fwd_val <= s1_nxt;
    end
  end

  // One RAM bank per access kind.
  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_bank
    logic bank_re;
    logic bank_we;
    assign bank_re = (s0_op != OP_NONE) && (s0_kind == k[0]);
    assign bank_we = s1_we && (s1_kind == k[0]);
    pac_ram #(
      .DEPTH (NUM_PAGES),
      .DW    (CW)
    ) u_ram (
      .clk   (clk),
      .re    (bank_re),
      .raddr (s0_page),
      .rdata (bank_q[k]),
      .we    (bank_we),
      .waddr (s1_page),
      .wdata (s1_nxt)
    );
  end

  assign s1_cur = s1_fwd ? s1_fwd_val : bank_q[s1_kind];

  pac_rmw #(
    .DW (CW)
  ) u_rmw (
    .op      (s1_op),
    .cur     (s1_cur),
    .set_val (s1_data),
    .we      (s1_we),
    .nxt     (s1_nxt),
    .alarm   (s1_alarm)
  );

  assign sw_rdata_valid = (s1_op == OP_GET);
  assign sw_rdata       = s1_cur;

  pac_pend #(
    .PW (PW)
  ) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (s1_alarm),
    .ev_page (s1_page),
    .ev_kind (s1_kind),
    .clr     (irq_clr),
    .pending (irq),
    .page    (irq_page),
    .kind    (irq_kind)
  );
endmodule

// File: rtl/pac_alarm_chk.sv
module pac_alarm_chk #(
  parameter int unsigned PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          acc_ready,
  input logic          sw_valid,
  input logic          sw_write,
  input logic          sw_rdata_valid,
  input logic          irq,
  input logic [PW-1:0] irq_page,
  input logic          irq_kind,
  input logic          irq_clr
);
  AST_STALL_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_valid && !sw_write) |-> !acc_ready); // R7
  AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_valid |-> acc_ready); // R1
  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_valid && !sw_write) |=> sw_rdata_valid); // R5
  AST_READ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rdata_valid |-> $past(sw_valid && !sw_write)); // R5
  AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> (irq && $stable(irq_page) && $stable(irq_kind))); // R9
  AST_IRQ_FROM_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(acc_valid && acc_ready, 2)); // R4
endmodule

bind pac_alarm_top pac_alarm_chk #(.PW(PW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .acc_valid      (acc_valid),
  .acc_ready      (acc_ready),
  .sw_valid       (sw_valid),
  .sw_write       (sw_write),
  .sw_rdata_valid (sw_rdata_valid),
  .irq            (irq),
  .irq_page       (irq_page),
  .irq_kind       (irq_kind),
  .irq_clr        (irq_clr)
);

// File: tb/tb_pac_alarm_top.sv
module tb_pac_alarm_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [7:0]  acc_page = '0;
  logic        acc_write = 1'b0;
  logic        sw_valid = 1'b0;
  logic        sw_write = 1'b0;
  logic [7:0]  sw_page = '0;
  logic        sw_kind = 1'b0;
  logic [15:0] sw_wdata = '0;
  logic        sw_rdata_valid;
  logic [15:0] sw_rdata;
  logic        irq;
  logic [7:0]  irq_page;
  logic        irq_kind;
  logic        irq_clr = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  pac_alarm_top dut (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_page(acc_page), .acc_write(acc_write),
    .sw_valid(sw_valid), .sw_write(sw_write), .sw_page(sw_page),
    .sw_kind(sw_kind), .sw_wdata(sw_wdata),
    .sw_rdata_valid(sw_rdata_valid), .sw_rdata(sw_rdata),
    .irq(irq), .irq_page(irq_page), .irq_kind(irq_kind), .irq_clr(irq_clr)
  );

  typedef struct packed {
    logic [1:0]  op;    // 0 set, 1 access, 2 read-check, 3 irq-check
    logic        kind;
    logic [7:0]  page;
    logic [15:0] val;   // irq-check: {pending,6'b0,kind,page}
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 8'd5,   16'd3,     4'd5},
    '{2'd0, 1'b1, 8'd5,   16'd10,    4'd5},
    '{2'd2, 1'b0, 8'd5,   16'd3,     4'd5},
    '{2'd1, 1'b0, 8'd5,   16'd0,     4'd2},
    '{2'd1, 1'b0, 8'd5,   16'd0,     4'd2},
    '{2'd2, 1'b0, 8'd5,   16'd1,     4'd2},
    '{2'd2, 1'b1, 8'd5,   16'd10,    4'd2},
    '{2'd3, 1'b0, 8'd0,   16'h0000,  4'd4},
    '{2'd1, 1'b0, 8'd5,   16'd0,     4'd4},
    '{2'd3, 1'b0, 8'd0,   16'h8005,  4'd4},
    '{2'd1, 1'b0, 8'd5,   16'd0,     4'd3},
    '{2'd2, 1'b0, 8'd5,   16'd0,     4'd3},
    '{2'd3, 1'b0, 8'd0,   16'h0000,  4'd3},
    '{2'd0, 1'b1, 8'd200, 16'd1,     4'd4},
    '{2'd1, 1'b1, 8'd200, 16'd0,     4'd4},
    '{2'd3, 1'b0, 8'd0,   16'h81C8,  4'd4},
    '{2'd2, 1'b1, 8'd200, 16'd0,     4'd4}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sw_set(input logic [7:0] p, input logic k, input logic [15:0] v);
    sw_valid = 1'b1; sw_write = 1'b1; sw_page = p; sw_kind = k; sw_wdata = v;
    tick();
    sw_valid = 1'b0; sw_write = 1'b0;
    tick();
  endtask

  task automatic sw_get(input logic [7:0] p, input logic k, input logic [15:0] exp, input string tag);
    sw_valid = 1'b1; sw_write = 1'b0; sw_page = p; sw_kind = k;
    tick();
    check({tag, " rdata_valid"}, 32'(sw_rdata_valid), 32'd1);
    check({tag, " rdata"}, 32'(sw_rdata), 32'(exp));
    sw_valid = 1'b0;
    tick();
  endtask

  task automatic access(input logic [7:0] p, input logic k);
    acc_valid = 1'b1; acc_page = p; acc_write = k;
    tick();
    acc_valid = 1'b0;
    tick();
    tick();
  endtask

  function automatic logic [15:0] irq_word();
    return irq ? {1'b1, 6'b0, irq_kind, irq_page} : 16'h0000;
  endfunction

  task automatic clear_irq();
    irq_clr = 1'b1;
    tick();
    irq_clr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 rdata_valid", 32'(sw_rdata_valid), 32'd0);
    check("R1 acc_ready", 32'(acc_ready), 32'd1);

    // Table walk: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      case (VEC[i].op)
        2'd0: sw_set(VEC[i].page, VEC[i].kind, VEC[i].val);
        2'd1: access(VEC[i].page, VEC[i].kind);
        2'd2: sw_get(VEC[i].page, VEC[i].kind, VEC[i].val, tag);
        default: begin
          check(tag, 32'(irq_word()), 32'(VEC[i].val));
          clear_irq();
        end
      endcase
      tick();
    end

    // R6 and R10: burst of three, then an immediate read
    sw_set(8'd9, 1'b1, 16'd5);
    acc_valid = 1'b1; acc_page = 8'd9; acc_write = 1'b1;
    tick(); tick(); tick();
    acc_valid = 1'b0;
    sw_valid = 1'b1; sw_write = 1'b0; sw_page = 8'd9; sw_kind = 1'b1;
    tick();
    check("R10 read after burst", 32'(sw_rdata), 32'd2);
    sw_valid = 1'b0;
    tick();
    sw_get(8'd9, 1'b1, 16'd2, "R6 burst total");

    // R7: stall by a software read, then by a write to another entry
    sw_set(8'd10, 1'b0, 16'd4);
    sw_set(8'd12, 1'b0, 16'd7);
    acc_valid = 1'b1; acc_page = 8'd12; acc_write = 1'b0;
    sw_valid = 1'b1; sw_write = 1'b0; sw_page = 8'd10; sw_kind = 1'b0;
    #1;
    check("R7 ready low on read", 32'(acc_ready), 32'd0);
    @(negedge clk);
    check("R7 read during stall", 32'(sw_rdata), 32'd4);
    sw_valid = 1'b0;
    #1;
    check("R7 ready back", 32'(acc_ready), 32'd1);
    @(negedge clk);
    acc_valid = 1'b0;
    tick();
    sw_get(8'd12, 1'b0, 16'd6, "R7 stalled access counted once");
    acc_valid = 1'b1; acc_page = 8'd12; acc_write = 1'b0;
    sw_valid = 1'b1; sw_write = 1'b1; sw_page = 8'd10; sw_kind = 1'b0; sw_wdata = 16'd8;
    #1;
    check("R7 ready low on other write", 32'(acc_ready), 32'd0);
    acc_valid = 1'b0;
    @(negedge clk);
    sw_valid = 1'b0;
    tick();
    sw_get(8'd12, 1'b0, 16'd6, "R7 stalled access not taken");

    // R8: same-entry collision, software write wins
    sw_set(8'd11, 1'b1, 16'd4);
    acc_valid = 1'b1; acc_page = 8'd11; acc_write = 1'b1;
    sw_valid = 1'b1; sw_write = 1'b1; sw_page = 8'd11; sw_kind = 1'b1; sw_wdata = 16'd9;
    #1;
    check("R8 ready on collision", 32'(acc_ready), 32'd1);
    @(negedge clk);
    acc_valid = 1'b0; sw_valid = 1'b0;
    tick();
    sw_get(8'd11, 1'b1, 16'd9, "R8 write wins");

    // R9: first cause held, clear, then alarm coinciding with clear
    sw_set(8'd20, 1'b0, 16'd1);
    sw_set(8'd21, 1'b0, 16'd1);
    access(8'd20, 1'b0);
    check("R9 first cause", 32'(irq_word()), 32'h8014);
    access(8'd21, 1'b0);
    check("R9 cause held", 32'(irq_word()), 32'h8014);
    clear_irq();
    check("R9 cleared", 32'(irq), 32'd0);
    sw_set(8'd23, 1'b0, 16'd1);
    sw_set(8'd22, 1'b1, 16'd1);
    access(8'd23, 1'b0);
    check("R9 pending before clash", 32'(irq_word()), 32'h8017);
    acc_valid = 1'b1; acc_page = 8'd22; acc_write = 1'b1;
    tick();
    acc_valid = 1'b0;
    irq_clr = 1'b1;
    tick();
    irq_clr = 1'b0;
    check("R9 alarm on clear kept", 32'(irq_word()), 32'h8116);
    clear_irq();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule